// File: doc/BRIEF.md
# DMA Channel Register Bank

This block holds the software-visible state of a multi-channel DMA controller: one control/status word per channel, four address and command registers per channel, a shared alignment register, a programmed-I/O register and a read-only global interrupt register. A single 32-bit register port reads and writes it. One access can be presented per cycle. The read data and an error flag come back one cycle after the access.

The status word has mixed write behaviour. Some interrupt flags clear when a one is written to them. The control bits take the written value. A pair of write bits clears or sets a completion flag. The stopped flag follows the run state and the stop-interrupt enable. Writing a one to the run bit sends a one-cycle start pulse to the transfer engine. The pulse is tagged to say whether the engine fetches a descriptor first. The transfer engine is a separate block. It reports back through per-channel event inputs, which set the interrupt flags.

Top module: `dmab_regbank`

Byte offsets used throughout:
- Status word of channel c: 0x000 + 4·c.
- Alignment register: 0x0A0.
- Programmed-I/O register: 0x0A4.
- Global interrupt register: 0x0F0.
- Channel register block: 0x100 + 16·c + 4·i, where i selects the register.

Status word bit positions:

| Bit | Role |
|-----|------|
| 0 | bus-error flag |
| 1 | start flag |
| 2 | end flag |
| 3 | stopped |
| 4 | request-asserted flag |
| 9 | end-of-receive flag |
| 10 | completion |
| 22 | mask-run |
| 24 | clear-complete |
| 25 | set-complete |
| 29 | stop-interrupt enable |
| 30 | no-descriptor-fetch |
| 31 | run |

## Requirements
- R1: After reset, every status word reads 0x00000008 (stopped only), every other register reads 0, and irq is 1.
- R2: A status-word write keeps only bits 0,1,2,3,4,8,9,10 of the old value (mask 0x0000071F). Of these, bits 0, 1, 2 and 9 clear wherever the written value has a one.
- R3: The written bits 31..26 and 23 (mask 0xFC800000) are loaded into the status word. All other written bits are not stored.
- R4: A status write with bit 31 set clears the stopped flag and the request-asserted flag. It also drives start_pulse for that channel for exactly the one cycle after the access. start_fetch is 1 in that cycle when bit 30 was written 0, and 0 when bit 30 was written 1.
- R5: If bit 29 is set after a status write, the stopped flag clears. A write with both bit 31 and bit 22 at zero then sets the stopped flag, and this overrides bit 29.
- R6: Writing bit 24 clears completion (bit 10), and writing bit 25 sets it. When both are written, completion ends set.
- R7: At offset 0x100 + 16·c + 4·i, i = 0, 1, 2, 3 selects the descriptor address, source address, target address and command of channel c. Each register stores and returns all 32 bits.
- R8: The alignment register at 0x0A0 returns the written value unchanged. The programmed-I/O register at 0x0A4 stores only bits 31 and 0.
- R9: The register at 0x0F0 reads bit c as the OR of channel c's stopped, end-of-receive, request-asserted, start and end flags. irq is the OR of those bits. Writes to 0x0F0 change nothing.
- R10: An access to an unaligned or unmapped offset raises reg_err for the one cycle after it, returns 0 and leaves all state unchanged. This includes status words and channel blocks for channels at or above NUM_CH. Mapped accesses leave reg_err at 0.
- R11: A one-cycle pulse on ev_buserr, ev_start, ev_end, ev_req or ev_eor for channel c sets bit 0, 1, 2, 4 or 9 of its status word. An event in the same cycle as a status write to that channel takes priority over the write.
- R12: reg_rdata is registered and holds the addressed value in the cycle after the access.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| reg_en | input | 1 | access valid this cycle |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | byte offset |
| reg_wdata | input | 32 | write data |
| reg_rdata | output | 32 | read data, one cycle after the access |
| reg_err | output | 1 | bad-offset flag, one cycle after the access |
| ev_buserr | input | NUM_CH | per-channel bus-error event |
| ev_start | input | NUM_CH | per-channel start event |
| ev_end | input | NUM_CH | per-channel end event |
| ev_req | input | NUM_CH | per-channel request-asserted event |
| ev_eor | input | NUM_CH | per-channel end-of-receive event |
| start_pulse | output | NUM_CH | one-cycle channel start |
| start_fetch | output | NUM_CH | start is preceded by a descriptor fetch |
| irq | output | 1 | global interrupt summary |

## Verification
The assertions assume that reg_wdata, reg_we and reg_addr are meaningful only while reg_en is high. They also assume that a start pulse can only follow a write in which bit 31 of the written data was one. The stimulus therefore changes the access inputs only at falling edges, and returns reg_en and reg_we to zero between accesses. Event inputs are pulsed for one cycle at a time, either alone or in the same cycle as a status write, so that the event-priority rule is exercised.

// File: rtl/dmab_pkg.sv
package dmab_pkg;
    localparam int unsigned DW = 32;

    // status word bit positions
    localparam int unsigned B_BUSERR = 0;
    localparam int unsigned B_START  = 1;
    localparam int unsigned B_END    = 2;
    localparam int unsigned B_STOP   = 3;
    localparam int unsigned B_REQ    = 4;
    localparam int unsigned B_EOR    = 9;
    localparam int unsigned B_DONE   = 10;
    localparam int unsigned B_MRUN   = 22;
    localparam int unsigned B_CLRD   = 24;
    localparam int unsigned B_SETD   = 25;
    localparam int unsigned B_STOPEN = 29;
    localparam int unsigned B_NOFET  = 30;
    localparam int unsigned B_RUN    = 31;

    localparam logic [DW-1:0] KEEP_MASK = 32'h0000_071F;
    localparam logic [DW-1:0] CTRL_MASK = 32'hFC80_0000;
    localparam logic [DW-1:0] W1C_MASK  = 32'h0000_0207;
    localparam logic [DW-1:0] PIO_MASK  = 32'h8000_0001;
    localparam logic [DW-1:0] STAT_RST  = 32'h0000_0008;

    localparam int unsigned OFS_ALIGN = 'h0A0;
    localparam int unsigned OFS_PIO   = 'h0A4;
    localparam int unsigned OFS_GINT  = 'h0F0;
    localparam int unsigned OFS_CHBLK = 'h100;

    typedef enum logic [2:0] {
        K_NONE,
        K_STAT,
        K_ALIGN,
        K_PIO,
        K_GINT,
        K_CREG
    } reg_kind_e;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_DONE,
        ACC_FAULT
    } acc_state_e;

    typedef struct packed {
        logic buserr;
        logic start;
        logic fin;
        logic req;
        logic eor;
    } chan_evt_t;
endpackage

// File: rtl/dmab_decode.sv
module dmab_decode
    import dmab_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 10,
    localparam int unsigned CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [CH_W-1:0]   ch,
    output logic [1:0]        idx
);
    localparam int unsigned STAT_END = 4 * NUM_CH;
    localparam int unsigned BLK_END  = OFS_CHBLK + 16 * NUM_CH;

    int unsigned a;
    int unsigned blk_ofs;

    always_comb begin
        a       = int'(addr);
        blk_ofs = a - OFS_CHBLK;
        kind    = K_NONE;
        ch      = '0;
        idx     = addr[3:2];
        if (addr[1:0] == 2'b00) begin
            if (a < STAT_END) begin
                kind = K_STAT;
                ch   = addr[2 +: CH_W];
            end else if (a == OFS_ALIGN) begin
                kind = K_ALIGN;
            end else if (a == OFS_PIO) begin
                kind = K_PIO;
            end else if (a == OFS_GINT) begin
                kind = K_GINT;
            end else if (a >= OFS_CHBLK && a < BLK_END) begin
                kind = K_CREG;
                ch   = blk_ofs[4 +: CH_W];
            end
        end
    end
endmodule

// File: rtl/dmab_chan.sv
module dmab_chan
    import dmab_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_stat,
    input  logic          wr_creg,
    input  logic [1:0]    creg_idx,
    input  logic [DW-1:0] wdata,
    input  chan_evt_t     evt,
    output logic [DW-1:0] stat,
    output logic [DW-1:0] creg [4],
    output logic          start_q,
    output logic          fetch_q
);
    logic [DW-1:0] stat_d;
    logic          start_d;
    logic          fetch_d;

    // status word: write semantics first, then engine events on top
    always_comb begin
        stat_d  = stat;
        start_d = 1'b0;
        fetch_d = 1'b0;
        if (wr_stat) begin
            stat_d = stat & KEEP_MASK & ~(wdata & W1C_MASK);
            stat_d = stat_d | (wdata & CTRL_MASK);
            if (stat_d[B_STOPEN]) begin
                stat_d[B_STOP] = 1'b0;
            end
            if (wdata[B_RUN]) begin
                stat_d[B_STOP] = 1'b0;
                stat_d[B_REQ]  = 1'b0;
                start_d        = 1'b1;
                fetch_d        = !wdata[B_NOFET];
            end
            if (!wdata[B_RUN] && !wdata[B_MRUN]) begin
                stat_d[B_STOP] = 1'b1;
            end
            if (wdata[B_CLRD]) begin
                stat_d[B_DONE] = 1'b0;
            end
            if (wdata[B_SETD]) begin
                stat_d[B_DONE] = 1'b1;
            end
        end
        if (evt.buserr) stat_d[B_BUSERR] = 1'b1;
        if (evt.start)  stat_d[B_START]  = 1'b1;
        if (evt.fin)    stat_d[B_END]    = 1'b1;
        if (evt.req)    stat_d[B_REQ]    = 1'b1;
        if (evt.eor)    stat_d[B_EOR]    = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stat    <= STAT_RST;
            start_q <= 1'b0;
            fetch_q <= 1'b0;
        end else begin
            stat    <= stat_d;
            start_q <= start_d;
            fetch_q <= fetch_d;
        end
    end

    for (genvar i = 0; i < 4; i++) begin : g_creg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                creg[i] <= '0;
            end else if (wr_creg && creg_idx == 2'(i)) begin
                creg[i] <= wdata;
            end
        end
    end
endmodule

// File: rtl/dmab_access_fsm.sv
module dmab_access_fsm
    import dmab_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          acc_en,
    input  logic          acc_hit,
    input  logic [DW-1:0] rd_next,
    output logic [DW-1:0] rdata,
    output logic          err
);
    acc_state_e state_q;
    acc_state_e state_d;

    // next-state: every access ends in DONE or FAULT for one cycle
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE, ACC_DONE, ACC_FAULT: begin
                if (!acc_en)      state_d = ACC_IDLE;
                else if (acc_hit) state_d = ACC_DONE;
                else              state_d = ACC_FAULT;
            end
            default: state_d = ACC_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACC_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (acc_en) begin
            rdata <= acc_hit ? rd_next : '0;
        end
    end

    always_comb begin
        err = 1'b0;
        unique case (state_q)
            ACC_FAULT: err = 1'b1;
            ACC_IDLE, ACC_DONE: err = 1'b0;
            default: err = 1'b0;
        endcase
    end
endmodule

// File: rtl/dmab_regbank.sv
module dmab_regbank
    import dmab_pkg::*;
#(
    parameter int unsigned NUM_CH = 4,
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              reg_err,
    input  logic [NUM_CH-1:0] ev_buserr,
    input  logic [NUM_CH-1:0] ev_start,
    input  logic [NUM_CH-1:0] ev_end,
    input  logic [NUM_CH-1:0] ev_req,
    input  logic [NUM_CH-1:0] ev_eor,
    output logic [NUM_CH-1:0] start_pulse,
    output logic [NUM_CH-1:0] start_fetch,
    output logic              irq
);
    localparam int unsigned CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

    reg_kind_e       kind;
    logic [CH_W-1:0] sel_ch;
    logic [1:0]      sel_idx;
    logic            hit;
    logic [DW-1:0]   rd_next;
    logic [DW-1:0]   align_q;
    logic [DW-1:0]   pio_q;
    logic [DW-1:0]   stat  [NUM_CH];
    logic [DW-1:0]   cregs [NUM_CH][4];
    logic [NUM_CH-1:0] gint;

    dmab_decode #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_dec (
        .addr (reg_addr),
        .kind (kind),
        .ch   (sel_ch),
        .idx  (sel_idx)
    );

    assign hit = (kind != K_NONE);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        chan_evt_t evt;
        logic      wr_s;
        logic      wr_c;
        assign evt  = '{buserr: ev_buserr[c], start: ev_start[c], fin: ev_end[c],
                        req: ev_req[c], eor: ev_eor[c]};
        assign wr_s = reg_en && reg_we && kind == K_STAT && sel_ch == CH_W'(c);
        assign wr_c = reg_en && reg_we && kind == K_CREG && sel_ch == CH_W'(c);

        dmab_chan u_chan (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stat  (wr_s),
            .wr_creg  (wr_c),
            .creg_idx (sel_idx),
            .wdata    (reg_wdata),
            .evt      (evt),
            .stat     (stat[c]),
            .creg     (cregs[c]),
            .start_q  (start_pulse[c]),
            .fetch_q  (start_fetch[c])
        );

        assign gint[c] = stat[c][B_STOP] | stat[c][B_EOR] | stat[c][B_REQ]
                       | stat[c][B_START] | stat[c][B_END];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            align_q <= '0;
            pio_q   <= '0;
        end else if (reg_en && reg_we) begin
            if (kind == K_ALIGN) align_q <= reg_wdata;
            if (kind == K_PIO)   pio_q   <= reg_wdata & PIO_MASK;
        end
    end

    always_comb begin
        rd_next = '0;
        unique case (kind)
            K_STAT:  rd_next = stat[sel_ch];
            K_ALIGN: rd_next = align_q;
            K_PIO:   rd_next = pio_q;
            K_GINT:  rd_next = DW'(gint);
            K_CREG:  rd_next = cregs[sel_ch][sel_idx];
            K_NONE:  rd_next = '0;
            default: rd_next = '0;
        endcase
    end

    dmab_access_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .acc_en  (reg_en),
        .acc_hit (hit),
        .rd_next (rd_next),
        .rdata   (reg_rdata),
        .err     (reg_err)
    );

    assign irq = |gint;
endmodule

// File: rtl/dmab_regbank_chk.sv
module dmab_regbank_chk #(
    parameter int unsigned NUM_CH = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              reg_en,
    input logic              reg_we,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              reg_err,
    input logic [NUM_CH-1:0] start_pulse,
    input logic [NUM_CH-1:0] start_fetch
);
    AST_ERR_AFTER_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> $past(reg_en));                                             // R10
    AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> reg_rdata == 32'h0);                                        // R10
    AST_START_ONE_CHANNEL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_pulse));                                                 // R4
    AST_FETCH_ONLY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_fetch & ~start_pulse) == '0);                                    // R4
    AST_START_FROM_RUN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (|start_pulse) |-> $past(reg_en && reg_we && reg_wdata[31]));           // R4
    AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        reg_err |-> start_pulse == '0);                                         // R10
endmodule

bind dmab_regbank dmab_regbank_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_en      (reg_en),
    .reg_we      (reg_we),
    .reg_wdata   (reg_wdata),
    .reg_rdata   (reg_rdata),
    .reg_err     (reg_err),
    .start_pulse (start_pulse),
    .start_fetch (start_fetch)
);

// File: tb/test_dmab_regbank.sv
`timescale 1ns/1ps
module test_dmab_regbank;
    localparam int NCH = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_en = 1'b0;
    logic reg_we = 1'b0;
    logic [9:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic reg_err;
    logic [NCH-1:0] ev_buserr = '0, ev_start = '0, ev_end = '0, ev_req = '0, ev_eor = '0;
    logic [NCH-1:0] start_pulse, start_fetch;
    logic irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] r_data;
    logic r_err;
    logic [NCH-1:0] r_start, r_fetch;

    always #10 clk = ~clk;

    dmab_regbank #(.NUM_CH(NCH), .ADDR_W(10)) i_dmab_regbank (
        .clk(clk), .rst_n(rst_n), .reg_en(reg_en), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .ev_buserr(ev_buserr), .ev_start(ev_start),
        .ev_end(ev_end), .ev_req(ev_req), .ev_eor(ev_eor),
        .start_pulse(start_pulse), .start_fetch(start_fetch), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // ev_kind bits: 0 buserr, 1 start, 2 end, 3 req, 4 eor
    task automatic set_ev(input logic [NCH-1:0] m, input logic [4:0] k);
        ev_buserr = k[0] ? m : '0;
        ev_start  = k[1] ? m : '0;
        ev_end    = k[2] ? m : '0;
        ev_req    = k[3] ? m : '0;
        ev_eor    = k[4] ? m : '0;
    endtask

    task automatic acc(input logic we, input logic [9:0] a, input logic [31:0] d,
                       input logic [NCH-1:0] em = '0, input logic [4:0] ek = '0);
        @(negedge clk);
        reg_en = 1'b1; reg_we = we; reg_addr = a; reg_wdata = d;
        set_ev(em, ek);
        @(negedge clk);
        reg_en = 1'b0; reg_we = 1'b0;
        set_ev('0, '0);
        r_data = reg_rdata; r_err = reg_err; r_start = start_pulse; r_fetch = start_fetch;
    endtask

    task automatic wr(input logic [9:0] a, input logic [31:0] d);
        acc(1'b1, a, d);
    endtask

    task automatic rd_chk(input string req, input logic [9:0] a, input logic [31:0] exp);
        acc(1'b0, a, 32'h0);
        chk(req, r_data, exp);
        chk({req, " err"}, {31'h0, r_err}, 32'h0);
    endtask

    task automatic pulse_ev(input logic [NCH-1:0] m, input logic [4:0] k);
        @(negedge clk);
        set_ev(m, k);
        @(negedge clk);
        set_ev('0, '0);
    endtask

    task automatic t_reset;
        for (int c = 0; c < NCH; c++) rd_chk("R1 status", 10'(4 * c), 32'h0000_0008);
        rd_chk("R1 chreg", 10'h100, 32'h0);
        rd_chk("R1 align", 10'h0A0, 32'h0);
        chk("R1 irq", {31'h0, irq}, 32'h1);
    endtask

    task automatic t_w1c;
        wr(10'h004, 32'h2040_0000);
        rd_chk("R5 stopen clears stop", 10'h004, 32'h2000_0000);
        pulse_ev(4'b0010, 5'b11111);
        rd_chk("R11 events set flags", 10'h004, 32'h2000_0217);
        wr(10'h004, 32'h2040_0005);
        rd_chk("R2 w1c bits 0,2", 10'h004, 32'h2000_0212);
        acc(1'b1, 10'h004, 32'h2040_0202, 4'b0010, 5'b00010);
        rd_chk("R11 event beats write", 10'h004, 32'h2000_0012);
    endtask

    task automatic t_ctrl;
        wr(10'h008, 32'h7FFF_FFFF);
        chk("R3 no start without run", {28'h0, r_start}, 32'h0);
        rd_chk("R3 ctrl load", 10'h008, 32'h7C80_0400);
        wr(10'h008, 32'h0000_0000);
        rd_chk("R5 halt sets stop", 10'h008, 32'h0000_0408);
    endtask

    task automatic t_run;
        wr(10'h00C, 32'h8000_0000);
        chk("R4 start pulse", {28'h0, r_start}, 32'h8);
        chk("R4 fetch tag", {28'h0, r_fetch}, 32'h8);
        @(negedge clk);
        chk("R4 pulse one cycle", {28'h0, start_pulse}, 32'h0);
        rd_chk("R4 run state", 10'h00C, 32'h8000_0000);
        pulse_ev(4'b1000, 5'b01000);
        rd_chk("R11 req flag", 10'h00C, 32'h8000_0010);
        wr(10'h00C, 32'hC000_0000);
        chk("R4 nofetch start", {28'h0, r_start}, 32'h8);
        chk("R4 nofetch tag", {28'h0, r_fetch}, 32'h0);
        rd_chk("R4 req cleared", 10'h00C, 32'hC000_0000);
    endtask

    task automatic t_stop;
        wr(10'h000, 32'h2000_0000);
        rd_chk("R5 halt beats stopen", 10'h000, 32'h2000_0008);
        wr(10'h000, 32'h0040_0000);
        rd_chk("R5 maskrun keeps stop", 10'h000, 32'h0000_0008);
        wr(10'h000, 32'h2040_0000);
        rd_chk("R5 stopen clears", 10'h000, 32'h2000_0000);
    endtask

    task automatic t_complete;
        wr(10'h000, 32'h0240_0000);
        rd_chk("R6 set", 10'h000, 32'h0000_0400);
        wr(10'h000, 32'h0140_0000);
        rd_chk("R6 clear", 10'h000, 32'h0000_0000);
        wr(10'h000, 32'h0340_0000);
        rd_chk("R6 set wins", 10'h000, 32'h0000_0400);
    endtask

    task automatic t_chregs;
        for (int i = 0; i < 4; i++) wr(10'(16'h110 + 4 * i), 32'hA5A5_0000 + 32'(i));
        for (int i = 0; i < 4; i++) rd_chk("R7 ch1 regs", 10'(16'h110 + 4 * i), 32'hA5A5_0000 + 32'(i));
        wr(10'h138, 32'hFFFF_FFFF);
        rd_chk("R7 ch3 target", 10'h138, 32'hFFFF_FFFF);
        rd_chk("R7 ch0 untouched", 10'h100, 32'h0);
        rd_chk("R12 ch3 cmd", 10'h13C, 32'h0);
    endtask

    task automatic t_align_pio;
        wr(10'h0A0, 32'hDEAD_BEEF);
        rd_chk("R8 align", 10'h0A0, 32'hDEAD_BEEF);
        wr(10'h0A4, 32'hFFFF_FFFF);
        rd_chk("R8 pio mask", 10'h0A4, 32'h8000_0001);
        wr(10'h0A4, 32'h7FFF_FFFE);
        rd_chk("R8 pio zero", 10'h0A4, 32'h0);
    endtask

    task automatic t_gint;
        rd_chk("R9 summary", 10'h0F0, 32'h6);
        chk("R9 irq", {31'h0, irq}, 32'h1);
        wr(10'h0F0, 32'hFFFF_FFFF);
        rd_chk("R9 write ignored", 10'h0F0, 32'h6);
        wr(10'h004, 32'hE040_0002);
        wr(10'h008, 32'h2040_0000);
        rd_chk("R9 all quiet", 10'h0F0, 32'h0);
        chk("R9 irq low", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_unmapped;
        acc(1'b0, 10'h0A8, 32'h0);
        chk("R10 err read", {31'h0, r_err}, 32'h1);
        chk("R10 zero data", r_data, 32'h0);
        acc(1'b1, 10'h0A2, 32'h0);
        chk("R10 err unaligned", {31'h0, r_err}, 32'h1);
        acc(1'b1, 10'h010, 32'h8000_0000);
        chk("R10 err stat ch4", {31'h0, r_err}, 32'h1);
        chk("R10 no start", {28'h0, r_start}, 32'h0);
        acc(1'b1, 10'h140, 32'h1234_5678);
        chk("R10 err chblk ch4", {31'h0, r_err}, 32'h1);
        rd_chk("R10 align unchanged", 10'h0A0, 32'hDEAD_BEEF);
        rd_chk("R10 ch0 unchanged", 10'h000, 32'h0000_0400);
        rd_chk("R10 ch0 desc unchanged", 10'h100, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_w1c();
        t_ctrl();
        t_run();
        t_stop();
        t_complete();
        t_chregs();
        t_align_pio();
        t_gint();
        t_unmapped();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=%08h expected=%08h", 32'h1, 32'h0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule